// File: doc/BRIEF.md
# Crosspoint Route Memory with Serial Read-Back

This block holds the routing set-up of a crosspoint switch with 37 output slices. Each slice keeps a 7-bit word that names the input routed to it. A parallel write port updates one slice per clock. A per-slice output-enable flag is derived from the stored word. The all-ones code 127 names no real input, so a slice holding it is treated as unrouted and powered down. Writing any other code brings the slice back.

A slow serial interface reads the whole table back. It has a shift clock, a serial-mode level and a scan-enable level, and all three are synchronised into the system clock domain. First, one shift-clock rising edge with serial mode high and scan-enable low copies every slice word at once into a 259-bit shift register. After that, every shift-clock rising edge with scan-enable high moves the stream forward by one bit. The serial output always shows the bit currently at the head of the register. The stream starts with the highest slice and ends with slice 0, and each word is sent most significant bit first.

Top module: `xcfg_route_mem`

## Requirements
- R1: After synchronous reset every slice holds 127, every bit of `out_en` is low and `sdo` is low.
- R2: A write with `wr_en` high and `wr_addr` below 37 stores `wr_data` into that slice at the next clock edge.
- R3: A write whose `wr_addr` is 37 or more changes no slice.
- R4: `out_en[i]` is low exactly when slice i holds 127. Writing any other code to the slice raises it again.
- R5: A synchronised shift-clock rising edge with `ser_mode` high and `scan_en` low loads every slice into the shift register. `sdo` then shows bit 6 of slice 36.
- R6: A synchronised shift-clock rising edge with `scan_en` high advances `sdo` by one bit. Over 259 positions the stream runs from slice 36 down to slice 0, each word from bit 6 to bit 0.
- R7: A shift-clock rising edge with both `ser_mode` and `scan_en` low leaves the shift register and `sdo` unchanged.
- R8: Slice writes made after a capture do not alter the bits already held for read-back.
- R9: `sdo` changes at the third clock edge after `sclk` rises (with two synchroniser stages). A falling `sclk` moves nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slice write strobe |
| wr_addr | input | 6 | Slice index to write |
| wr_data | input | 7 | Input-select code to store |
| sclk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_mode | input | 1 | Serial mode level; with `scan_en` low, a shift-clock rise captures |
| scan_en | input | 1 | Scan enable; a shift-clock rise shifts |
| sdo | output | 1 | Serial read-back data, head of the shift register |
| out_en | output | 37 | Per-slice enable, low for code 127 |

## Verification
The bench builds the block with its default parameters: 37 slices of 7 bits and two synchroniser stages. At that size it can walk the whole 259-bit stream several times. It can also use out-of-range addresses from 37 to 63 inside the 6-bit address field. Because the stage count is known, the bench can predict the exact clock edge on which `sdo` moves after a shift-clock edge. Full streams are compared against a table the bench keeps. This covers the cases where a capture follows a reset, a write pattern, interrupted scanning and writes made partway through a read-back.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

  // Operation applied to the read-back register on a clock edge
  typedef enum logic [1:0] {
    SR_HOLD    = 2'd0,
    SR_CAPTURE = 2'd1,
    SR_SHIFT   = 2'd2
  } sr_op_e;

endpackage

// File: rtl/xcfg_slice_mem.sv
module xcfg_slice_mem #(
  parameter int NUM_SLICES = 37,
  parameter int WORD_W     = 7,
  parameter int ADDR_W     = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [NUM_SLICES*WORD_W-1:0] snap,
  output logic [NUM_SLICES-1:0]        out_en
);

  localparam logic [WORD_W-1:0] OFF_CODE  = {WORD_W{1'b1}};
  localparam logic [ADDR_W:0]   ADDR_LIM  = (ADDR_W+1)'(NUM_SLICES);

  logic [WORD_W-1:0] word_q [NUM_SLICES];
  logic              addr_ok;

  assign addr_ok = ({1'b0, wr_addr} < ADDR_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLICES; i++) word_q[i] <= OFF_CODE;
    end else if (wr_en && addr_ok) begin
      word_q[wr_addr] <= wr_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SLICES; g++) begin : g_slice
      assign snap[g*WORD_W +: WORD_W] = word_q[g];
      assign out_en[g]                = (word_q[g] != OFF_CODE);
    end
  endgenerate

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_ok) |=> (word_q[$past(wr_addr)] == $past(wr_data)));

  // R3
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> $stable(snap));

  // R4
  off_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_ok && wr_data == OFF_CODE) |=> !out_en[$past(wr_addr)]);

endmodule

// File: rtl/xcfg_serial_ctrl.sv
module xcfg_serial_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             ser_mode,
  input  logic             scan_en,
  output xcfg_pkg::sr_op_e op
);
  import xcfg_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  // bit 2: shift clock, bit 1: serial mode, bit 0: scan enable
  logic [SYNC_STAGES-1:0][2:0] sync_q;
  logic                        sclk_prev_q;
  logic                        rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sync_q[0] <= {sclk, ser_mode, scan_en};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      sclk_prev_q <= sync_q[LAST][2];
    end
  end

  assign rise = sync_q[LAST][2] & ~sclk_prev_q;

  always_comb begin
    op = SR_HOLD;
    if (rise && sync_q[LAST][0])      op = SR_SHIFT;
    else if (rise && sync_q[LAST][1]) op = SR_CAPTURE;
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (op != SR_HOLD) |=> (op == SR_HOLD));

endmodule

// File: rtl/xcfg_readback_sr.sv
module xcfg_readback_sr #(
  parameter int TOTAL_BITS = 259
) (
  input  logic                  clk,
  input  logic                  rst,
  input  xcfg_pkg::sr_op_e      op,
  input  logic [TOTAL_BITS-1:0] snap,
  output logic                  sdo
);
  import xcfg_pkg::*;

  logic [TOTAL_BITS-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else begin
      case (op)
        SR_CAPTURE: sr_q <= snap;
        SR_SHIFT:   sr_q <= {sr_q[TOTAL_BITS-2:0], 1'b0};
        default:    sr_q <= sr_q;
      endcase
    end
  end

  assign sdo = sr_q[TOTAL_BITS-1];

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (op == SR_CAPTURE) |=> (sr_q == $past(snap)));

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (op == SR_SHIFT) |=> (sdo == $past(sr_q[TOTAL_BITS-2]) && !sr_q[0]));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == SR_HOLD) |=> $stable(sr_q));

endmodule

// File: rtl/xcfg_route_mem.sv
module xcfg_route_mem #(
  parameter int NUM_SLICES  = 37,
  parameter int WORD_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int TOTAL_BITS = NUM_SLICES * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  sclk,
  input  logic                  ser_mode,
  input  logic                  scan_en,
  output logic                  sdo,
  output logic [NUM_SLICES-1:0] out_en
);
  import xcfg_pkg::*;

  logic [TOTAL_BITS-1:0] snap;
  sr_op_e                op;

  xcfg_slice_mem #(
    .NUM_SLICES (NUM_SLICES),
    .WORD_W     (WORD_W),
    .ADDR_W     (ADDR_W)
  ) mem_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .snap    (snap),
    .out_en  (out_en)
  );

  xcfg_serial_ctrl #(
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .ser_mode (ser_mode),
    .scan_en  (scan_en),
    .op       (op)
  );

  xcfg_readback_sr #(
    .TOTAL_BITS (TOTAL_BITS)
  ) sr_i (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .snap (snap),
    .sdo  (sdo)
  );

  // R1
  post_reset_chk: assert property (@(posedge clk)
    $fell(rst) |-> (out_en == '0 && !sdo));

endmodule

// File: tb/xcfg_route_mem_tb_top.sv
module xcfg_route_mem_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 37;
  localparam int WW   = 7;
  localparam int AW   = 6;
  localparam int TB   = NS * WW;
  localparam int HALF = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic          sclk = 1'b0;
  logic          ser_mode = 1'b0;
  logic          scan_en = 1'b0;
  logic          sdo;
  logic [NS-1:0] out_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  logic [WW-1:0] model [NS];
  logic [TB-1:0] got;
  int            got_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcfg_route_mem dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sclk(sclk), .ser_mode(ser_mode), .scan_en(scan_en), .sdo(sdo), .out_en(out_en)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [TB-1:0] act, input logic [TB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [TB-1:0] model_stream();
    logic [TB-1:0] v;
    for (int i = 0; i < NS; i++) v[i*WW +: WW] = model[i];
    return v;
  endfunction

  function automatic logic [NS-1:0] model_en();
    logic [NS-1:0] v;
    for (int i = 0; i < NS; i++) v[i] = (model[i] != 7'h7F);
    return v;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; idle(HALF);
    sclk = 1'b0; idle(HALF);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sclk = 0; ser_mode = 0; scan_en = 0; wr_en = 0;
    idle(4);
    rst = 1'b0;
    for (int i = 0; i < NS; i++) model[i] = 7'h7F;
    idle(1);
  endtask

  task automatic write_slice(input logic [AW-1:0] a, input logic [WW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    idle(1);
    wr_en = 1'b0;
    if (a < NS) model[a] = d;
  endtask

  task automatic capture();
    scan_en = 1'b0; ser_mode = 1'b1; idle(HALF);
    sclk_pulse();
    got = '0; got_idx = 0;
  endtask

  task automatic read_bits(input int n);
    scan_en = 1'b1; idle(HALF);
    for (int k = 0; k < n; k++) begin
      got[TB-1-got_idx] = sdo;
      got_idx++;
      sclk_pulse();
    end
    scan_en = 1'b0; idle(HALF);
  endtask

  task automatic t_reset();
    do_reset();
    check(out_en == '0, "R1", "out_en after reset", TB'(out_en), '0);
    check(sdo == 1'b0, "R1", "sdo after reset", TB'(sdo), '0);
    capture();
    read_bits(TB);
    check(got == {TB{1'b1}}, "R1", "stream after reset", got, {TB{1'b1}});
  endtask

  task automatic t_write_pattern();
    for (int i = 0; i < NS; i++) write_slice(AW'(i), WW'((i * 37 + 11) % 127));
    check(out_en == model_en(), "R4", "out_en with all routed", TB'(out_en), TB'(model_en()));
    capture();
    check(sdo == model[NS-1][WW-1], "R5", "sdo after capture", TB'(sdo), TB'(model[NS-1][WW-1]));
    read_bits(TB);
    check(got == model_stream(), "R2", "stream after pattern write", got, model_stream());
    check(got[TB-1 -: WW] == model[NS-1], "R6", "first word is top slice", TB'(got[TB-1 -: WW]), TB'(model[NS-1]));
    check(got[WW-1:0] == model[0], "R6", "last word is slice 0", TB'(got[WW-1:0]), TB'(model[0]));
  endtask

  task automatic t_bad_addr();
    write_slice(6'd37, 7'h05);
    write_slice(6'd40, 7'h15);
    write_slice(6'd63, 7'h7F);
    check(out_en == model_en(), "R3", "out_en after bad addr", TB'(out_en), TB'(model_en()));
    capture();
    read_bits(TB);
    check(got == model_stream(), "R3", "stream after bad addr", got, model_stream());
  endtask

  task automatic t_power_down();
    write_slice(6'd3, 7'h7F);
    write_slice(6'd36, 7'h7F);
    check(out_en[3] == 1'b0 && out_en[36] == 1'b0, "R4", "disabled slices",
          TB'(out_en), TB'(model_en()));
    check(out_en == model_en(), "R4", "others still enabled", TB'(out_en), TB'(model_en()));
    write_slice(6'd3, 7'h7E);
    check(out_en[3] == 1'b1, "R4", "re-enable slice 3", TB'(out_en[3]), TB'(1));
    write_slice(6'd36, 7'h00);
    check(out_en == model_en(), "R4", "re-enable slice 36", TB'(out_en), TB'(model_en()));
  endtask

  task automatic t_idle_edges();
    logic held;
    capture();
    read_bits(10);
    held = sdo;
    ser_mode = 1'b0; scan_en = 1'b0; idle(HALF);
    repeat (3) sclk_pulse();
    check(sdo == held, "R7", "sdo across idle edges", TB'(sdo), TB'(held));
    ser_mode = 1'b1;
    read_bits(TB - 10);
    check(got == model_stream(), "R7", "stream across idle edges", got, model_stream());
  endtask

  task automatic t_write_during();
    logic [TB-1:0] snap_exp;
    snap_exp = model_stream();
    capture();
    read_bits(20);
    write_slice(6'd36, 7'h11);
    write_slice(6'd0, 7'h22);
    write_slice(6'd18, 7'h7F);
    read_bits(TB - 20);
    check(got == snap_exp, "R8", "stream with mid-scan writes", got, snap_exp);
    capture();
    read_bits(TB);
    check(got == model_stream(), "R8", "next capture sees new writes", got, model_stream());
  endtask

  task automatic t_latency();
    write_slice(6'd36, 7'b1010000);
    capture();
    scan_en = 1'b1; idle(HALF);
    check(sdo == 1'b1, "R9", "head bit before edge", TB'(sdo), TB'(1));
    sclk = 1'b1;
    idle(2);
    check(sdo == 1'b1, "R9", "sdo held two edges after rise", TB'(sdo), TB'(1));
    idle(1);
    check(sdo == 1'b0, "R9", "sdo moves on third edge", TB'(sdo), TB'(0));
    idle(1);
    sclk = 1'b0;
    idle(HALF + 2);
    check(sdo == 1'b0, "R9", "falling sclk moves nothing", TB'(sdo), TB'(0));
    scan_en = 1'b0; idle(HALF);
  endtask

  initial begin
    t_reset();
    t_write_pattern();
    t_bad_addr();
    t_power_down();
    t_idle_edges();
    t_write_during();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule